// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The engine walks a ring of transmit descriptors held in system memory and feeds the bytes they describe, one per handshake, to a MAC transmit stream. Software fills a descriptor, hands it over by setting its ownership bit, and then either writes a poll-demand bit or waits for the periodic poll. The engine reads the descriptor and then the buffer. It streams the bytes with frame start and end markers. It then writes the info word back with ownership returned to software and raises a transmit-done status bit.

Registers (word address on `reg_addr`): 0 control, 1 status, 2 interrupt enable, 3 ring base address, 4 poll interval in clock cycles. Control bit 0 is the global enable, bit 3 is the transmit enable, and bits 23:16 give the number of ring entries. Status bit 0 is transmit done and bit 3 is a chaining error. Both are cleared by writing 1. Writing 1 to status bit 31 requests a poll, and that bit always reads 0. The interrupt enable register uses the status bit positions.

The byte stream is valid/ready. A byte moves on a rising edge where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, the data and both markers hold still. The sink may hold `tx_ready` low for any number of cycles. The memory port is request/acknowledge: the request, address, write flag and write data hold until `mem_ack`. `mem_rdata` is taken in the cycle `mem_ack` is high.

Top module: `txring_engine`

## Requirements
- R1: Descriptor n occupies two words at ring base + 8*n: the info word, then the buffer byte address. In the info word, bit 31 is ownership (1 = engine), bit 16 is first buffer, bit 17 is last buffer, and bits 10:0 are the byte length. Bytes are read little-endian from the buffer, starting at the byte lane given by the low two address bits.
- R2: No memory access starts unless control bits 0 and 3 are both set.
- R3: Writing 1 to status bit 31 makes the engine read the current descriptor within a few cycles. Status bit 31 reads as 0.
- R4: While idle and with a nonzero poll interval, the engine re-reads the current descriptor about once per interval. A descriptor with ownership 0 leaves the index unchanged and sends nothing.
- R5: Each byte is held under back-pressure. `tx_first` is high only on the first byte of a first-buffer descriptor. `tx_last` is high only on the final byte of a last-buffer descriptor.
- R6: After a descriptor is sent, its info word is rewritten with bit 31 cleared. Length, first and last are kept, and flag bits 21, 22, 23, 24, 28 and 29 are written as 0.
- R7: Status bit 0 is set after a last-buffer descriptor completes, and not after a descriptor without the last bit.
- R8: The ring index advances after every descriptor and wraps to 0 after entry (control[23:16] − 1). The engine fetches the next descriptor without needing a new poll.
- R9: A first bit is expected after reset and after a last-buffer descriptor, and not expected otherwise. A descriptor that breaks this expectation sets status bit 3 and sends no bytes. It is written back with bit 31 cleared and bit 23 set, and a first bit is expected next.
- R10: Status bits 0 and 3 clear on a write of 1. `irq` is the OR of each status bit ANDed with the same bit of the interrupt enable register.
- R11: After reset all registers read 0, and `tx_valid`, `mem_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of frame |
| tx_last | output | 1 | Last byte of frame |

## Verification
Internal faults show up at the ports soon after they occur. A wrong byte-lane or pointer step gives a bad stream byte in the cycle it is presented. A wrong ring index shows as a write-back to the wrong descriptor word, and a wrong first/last expectation as a spurious chaining error. Both appear within a few cycles of the descriptor's end. A broken poll timer changes how many descriptor reads appear over a fixed idle window. Faults in the status logic show on `irq` and on register reads right after completion.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W   = 32;
  localparam int OWN_B    = 31;
  localparam int FIRST_B  = 16;
  localparam int LAST_B   = 17;
  localparam int DROP_B   = 23;
  localparam logic [WORD_W-1:0] FLAG_MASK = 32'h31E0_0000;
  localparam int ST_DONE  = 0;
  localparam int ST_CHAIN = 3;
  localparam int ST_POLL  = 31;
  localparam int CT_EN    = 0;
  localparam int CT_TXEN  = 3;
  localparam int CT_LEN_LO = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_INFO, S_ADDR, S_DATA, S_SEND, S_WB
  } txr_state_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs import txr_pkg::*; #(
  parameter int POLL_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              set_done,
  input  logic              set_chain,
  output logic              run_en,
  output logic [IDX_W-1:0]  ring_len,
  output logic [31:0]       ring_base,
  output logic [POLL_W-1:0] interval,
  output logic              poll_kick,
  output logic              irq
);
  logic en_g, en_tx, st_done, st_chain, ie_done, ie_chain;
  logic wr_ctl, wr_st, wr_ie;

  assign wr_ctl    = reg_wr && reg_addr == 3'd0;
  assign wr_st     = reg_wr && reg_addr == 3'd1;
  assign wr_ie     = reg_wr && reg_addr == 3'd2;
  assign poll_kick = wr_st && reg_wdata[ST_POLL];
  assign run_en    = en_g && en_tx;
  assign irq       = (st_done && ie_done) || (st_chain && ie_chain);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_g <= 1'b0; en_tx <= 1'b0; ring_len <= '0; ring_base <= '0;
      interval <= '0; st_done <= 1'b0; st_chain <= 1'b0;
      ie_done <= 1'b0; ie_chain <= 1'b0;
    end else begin
      if (wr_ctl) begin
        en_g     <= reg_wdata[CT_EN];
        en_tx    <= reg_wdata[CT_TXEN];
        ring_len <= reg_wdata[CT_LEN_LO +: IDX_W];
      end
      if (wr_ie) begin
        ie_done  <= reg_wdata[ST_DONE];
        ie_chain <= reg_wdata[ST_CHAIN];
      end
      if (reg_wr && reg_addr == 3'd3) ring_base <= reg_wdata;
      if (reg_wr && reg_addr == 3'd4) interval <= reg_wdata[POLL_W-1:0];
      st_done  <= set_done  || (st_done  && !(wr_st && reg_wdata[ST_DONE]));
      st_chain <= set_chain || (st_chain && !(wr_st && reg_wdata[ST_CHAIN]));
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: begin
        reg_rdata[CT_EN] = en_g;
        reg_rdata[CT_TXEN] = en_tx;
        reg_rdata[CT_LEN_LO +: IDX_W] = ring_len;
      end
      3'd1: begin
        reg_rdata[ST_DONE] = st_done;
        reg_rdata[ST_CHAIN] = st_chain;
      end
      3'd2: begin
        reg_rdata[ST_DONE] = ie_done;
        reg_rdata[ST_CHAIN] = ie_chain;
      end
      3'd3: reg_rdata = ring_base;
      3'd4: reg_rdata[POLL_W-1:0] = interval;
      default: reg_rdata = '0;
    endcase
  end

  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> st_done);
  assert_chain_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_chain |=> st_chain);
  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && reg_wdata[ST_DONE] && !set_done) |=> !st_done);
endmodule

// File: rtl/txr_poll.sv
module txr_poll #(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [POLL_W-1:0] interval,
  output logic              tick
);
  logic [POLL_W-1:0] cnt;
  logic live;

  assign live = run && (interval != '0);
  assign tick = live && (cnt >= interval - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !live || tick) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txr_fetch.sv
module txr_fetch import txr_pkg::*; #(
  parameter int IDX_W = 8,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [IDX_W-1:0] ring_len,
  input  logic [31:0]      ring_base,
  input  logic             poll_kick,
  input  logic             poll_tick,
  output logic             idle,
  output logic             set_done,
  output logic             set_chain,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_first,
  output logic             tx_last
);
  localparam int PAD_W = 32 - IDX_W - 3;

  txr_state_e state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   idx_inc;
  logic [31:0]      info, ptr, word, desc_addr;
  logic [LEN_W-1:0] remain;
  logic [1:0]       bsel;
  logic             pend, exp_first, bad, sent_any, go, owned, mismatch;

  assign idx_inc   = {1'b0, idx} + 1'b1;
  assign desc_addr = ring_base + {{PAD_W{1'b0}}, idx, 3'b000};
  assign idle      = (state == S_IDLE);
  assign go        = idle && run_en && (pend || poll_tick);
  assign owned     = mem_rdata[OWN_B];
  assign mismatch  = mem_rdata[FIRST_B] != exp_first;
  assign set_chain = (state == S_INFO) && mem_ack && owned && mismatch;
  assign set_done  = (state == S_WB) && mem_ack && !bad && info[LAST_B];

  assign mem_req   = (state == S_INFO) || (state == S_ADDR) ||
                     (state == S_DATA) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_wdata = (info & ~FLAG_MASK & ~(32'd1 << OWN_B)) |
                     (bad ? (32'd1 << DROP_B) : 32'd0);
  always_comb begin
    case (state)
      S_ADDR:  mem_addr = desc_addr + 32'd4;
      S_DATA:  mem_addr = ptr;
      default: mem_addr = desc_addr;
    endcase
  end

  assign tx_valid = (state == S_SEND);
  assign tx_data  = word[{bsel, 3'b000} +: 8];
  assign tx_first = tx_valid && info[FIRST_B] && !sent_any;
  assign tx_last  = tx_valid && info[LAST_B] && (remain == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; idx <= '0; info <= '0; ptr <= '0; word <= '0;
      remain <= '0; bsel <= '0; pend <= 1'b0; exp_first <= 1'b1;
      bad <= 1'b0; sent_any <= 1'b0;
    end else begin
      pend <= poll_kick || (pend && !go);
      case (state)
        S_IDLE: if (go) state <= S_INFO;
        S_INFO: if (mem_ack) begin
          if (!owned) state <= S_IDLE;
          else begin
            info  <= mem_rdata;
            bad   <= mismatch;
            state <= mismatch ? S_WB : S_ADDR;
          end
        end
        S_ADDR: if (mem_ack) begin
          ptr      <= {mem_rdata[31:2], 2'b00};
          bsel     <= mem_rdata[1:0];
          remain   <= info[LEN_W-1:0];
          sent_any <= 1'b0;
          state    <= (info[LEN_W-1:0] == '0) ? S_WB : S_DATA;
        end
        S_DATA: if (mem_ack) begin
          word  <= mem_rdata;
          state <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          remain   <= remain - 1'b1;
          bsel     <= bsel + 1'b1;
          sent_any <= 1'b1;
          if (remain == LEN_W'(1)) state <= S_WB;
          else if (bsel == 2'd3) begin
            ptr   <= ptr + 32'd4;
            state <= S_DATA;
          end
        end
        S_WB: if (mem_ack) begin
          idx       <= (idx_inc >= {1'b0, ring_len}) ? '0 : idx_inc[IDX_W-1:0];
          exp_first <= bad ? 1'b1 : info[LAST_B];
          state     <= run_en ? S_INFO : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_stream_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
                                 $stable(tx_first) && $stable(tx_last)));
  assert_mem_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_start_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(run_en));
  assert_one_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_first) |=> !tx_first);
endmodule

// File: rtl/txring_engine.sv
module txring_engine #(
  parameter int POLL_W = 16,
  parameter int IDX_W  = 8,
  parameter int LEN_W  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_first,
  output logic        tx_last
);
  logic              run_en, poll_kick, poll_tick, idle, set_done, set_chain;
  logic [IDX_W-1:0]  ring_len;
  logic [31:0]       ring_base;
  logic [POLL_W-1:0] interval;

  txr_regs #(.POLL_W(POLL_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_done(set_done),
    .set_chain(set_chain), .run_en(run_en), .ring_len(ring_len),
    .ring_base(ring_base), .interval(interval), .poll_kick(poll_kick),
    .irq(irq));

  txr_poll #(.POLL_W(POLL_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .run(idle && run_en), .interval(interval),
    .tick(poll_tick));

  txr_fetch #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ring_len(ring_len),
    .ring_base(ring_base), .poll_kick(poll_kick), .poll_tick(poll_tick),
    .idle(idle), .set_done(set_done), .set_chain(set_chain),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last));
endmodule

// File: tb/test_txring_engine.sv
`timescale 1ns/1ps
module test_txring_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic tx_valid, tx_ready = 1'b1, tx_first, tx_last;
  logic [7:0] tx_data;

  always #4 clk = ~clk;

  txring_engine i_txring_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last));

  logic [31:0] mem [256];
  int rd_cnt = 0, req_cnt = 0;
  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
    if (mem_req && mem_ack && !mem_we) rd_cnt <= rd_cnt + 1;
    if (mem_req) req_cnt <= req_cnt + 1;
  end

  // stream sink with optional back-pressure
  logic [7:0] got_d [64];
  logic got_f [64], got_l [64];
  int got_n = 0;
  logic bp_on = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = bp_on ? lfsr[0] : 1'b1;
    if (tx_valid && tx_ready && got_n < 64) begin
      got_d[got_n] = tx_data; got_f[got_n] = tx_first; got_l[got_n] = tx_last;
      got_n = got_n + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] pat(input int k, input int j);
    return 8'((k * 37 + j * 5 + 1) & 255);
  endfunction

  task automatic put_byte(input int addr, input logic [7:0] b);
    mem[addr >> 2][(addr & 3) * 8 +: 8] = b;
  endtask

  task automatic wait_own(input int didx, input int maxc);
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (!mem[didx * 2][31]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // check bytes got_d[base_n..] against pattern k, and markers
  task automatic check_frame(input int k, input int base_n, input int len,
                             input bit fm, input bit lm, input string tag);
    for (int j = 0; j < len; j++) begin
      check(got_d[base_n + j] == pat(k, j), "R1 byte", int'(got_d[base_n + j]), int'(pat(k, j)));
      check(got_f[base_n + j] == (fm && j == 0), "R5 first marker", int'(got_f[base_n + j]), int'(fm && j == 0));
      check(got_l[base_n + j] == (lm && j == len - 1), "R5 last marker", int'(got_l[base_n + j]), int'(lm && j == len - 1));
    end
    if (tag.len() == 0) ;
  endtask

  // vector table: {offset[1:0], len[10:0]}
  localparam logic [12:0] VEC [6] = '{
    {2'd0, 11'd1}, {2'd0, 11'd4}, {2'd1, 11'd7},
    {2'd3, 11'd13}, {2'd2, 11'd2}, {2'd0, 11'd9}};
  localparam logic [31:0] OWN = 32'h8000_0000, FST = 32'h0001_0000, LST = 32'h0002_0000;

  task automatic load_desc(input int didx, input int k, input int len, input int off,
                           input logic [31:0] flags);
    int ba;
    ba = 32'h100 + 32'h40 * k + off;
    for (int j = 0; j < len; j++) put_byte(ba + j, pat(k, j));
    mem[didx * 2 + 1] = 32'(ba);
    mem[didx * 2] = flags | 32'(len);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n0, r0, q0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      check(v == 0, "R11 register reset", int'(v), 0);
    end
    check(!tx_valid && !mem_req && !irq, "R11 outputs idle", int'({tx_valid, mem_req, irq}), 0);

    wr(3, 32'h0); wr(2, 32'h9); wr(4, 32'h0);
    // R2: transmit enable clear, global enable set
    wr(0, (32'd4 << 16) | 32'h1);
    load_desc(0, 9, 3, 0, OWN | FST | LST);
    q0 = req_cnt;
    wr(1, 32'h8000_0000);
    rd(1, v);
    check(v[31] == 1'b0, "R3 poll bit reads 0", int'(v[31]), 0);
    repeat (40) @(negedge clk);
    check(req_cnt == q0, "R2 no access when disabled", req_cnt - q0, 0);
    check(got_n == 0, "R2 no bytes when disabled", got_n, 0);
    mem[0] = '0;
    wr(0, (32'd4 << 16) | 32'h9);
    repeat (10) @(negedge clk);

    // table-driven frames; 6 descriptors over a 4-entry ring (R8 wrap)
    bp_on = 1'b1;
    for (int k = 0; k < 6; k++) begin
      int len, off, didx;
      len = int'(VEC[k][10:0]); off = int'(VEC[k][12:11]); didx = k % 4;
      n0 = got_n;
      load_desc(didx, k, len, off, OWN | FST | LST);
      wr(1, 32'h8000_0000);
      wait_own(didx, 400);
      check(got_n - n0 == len, "R5 byte count", got_n - n0, len);
      check_frame(k, n0, len, 1'b1, 1'b1, "R1");
      check(mem[didx * 2] == (FST | LST | 32'(len)), "R6 write-back",
            int'(mem[didx * 2]), int'(FST | LST | 32'(len)));
      rd(1, v);
      check(v[0] == 1'b1, "R7 done set", int'(v[0]), 1);
      check(irq == 1'b1, "R10 irq on done", int'(irq), 1);
      wr(1, 32'h1);
      rd(1, v);
      check(v[0] == 1'b0 && !irq, "R10 w1c done", int'({v[0], irq}), 0);
    end
    bp_on = 1'b0;
    got_n = 0;

    // R7/R8: two-buffer frame at index 2 and 3
    load_desc(2, 6, 5, 0, OWN | FST);
    wr(1, 32'h8000_0000);
    wait_own(2, 300);
    rd(1, v);
    check(v[0] == 1'b0, "R7 no done without last", int'(v[0]), 0);
    check(got_n == 5, "R5 first part count", got_n, 5);
    load_desc(3, 7, 3, 0, OWN | LST);
    wr(1, 32'h8000_0000);
    wait_own(3, 300);
    check(got_n == 8, "R8 continues into next entry", got_n, 8);
    check_frame(6, 0, 5, 1'b1, 1'b0, "R5");
    check_frame(7, 5, 3, 1'b0, 1'b1, "R5");
    rd(1, v);
    check(v[0] == 1'b1, "R7 done after last", int'(v[0]), 1);
    wr(1, 32'h1);

    // R9 chaining error at index 0 (wrapped): first expected, missing
    n0 = got_n;
    load_desc(0, 8, 4, 0, OWN | LST);
    wr(1, 32'h8000_0000);
    wait_own(0, 300);
    check(got_n == n0, "R9 no bytes on chain error", got_n - n0, 0);
    check(mem[0] == (LST | 32'h0080_0000 | 32'd4), "R9 write-back with drop",
          int'(mem[0]), int'(LST | 32'h0080_0000 | 32'd4));
    rd(1, v);
    check(v[3] == 1'b1 && v[0] == 1'b0, "R9 chain status", int'(v), 8);
    check(irq == 1'b1, "R10 irq on chain", int'(irq), 1);
    wr(1, 32'h8);
    rd(1, v);
    check(v[3] == 1'b0 && !irq, "R10 w1c chain", int'({v[3], irq}), 0);

    // R4 periodic poll at index 1
    mem[2] = '0;
    repeat (10) @(negedge clk);
    wr(4, 32'd30);
    r0 = rd_cnt;
    repeat (100) @(negedge clk);
    check(rd_cnt - r0 >= 2 && rd_cnt - r0 <= 4, "R4 periodic reads", rd_cnt - r0, 3);
    check(got_n == n0, "R4 unowned sends nothing", got_n - n0, 0);
    load_desc(1, 10, 6, 2, OWN | FST | LST);
    wait_own(1, 300);
    check(got_n - n0 == 6, "R4 poll picks up owned", got_n - n0, 6);
    check_frame(10, n0, 6, 1'b1, 1'b1, "R4");
    wr(4, 32'd0);
    finish_run();
  end
endmodule